// File: doc/BRIEF.md
# Master Receive Read Buffer Controller

This block handles the data field of a frame in which the local unit is the bus master reading from a slave. A read-type command code opens a frame. The first byte the bit engine delivers after that is the slave's announced byte count. The block latches it into a length register and raises no interrupt. Each later byte is pushed into an 8-entry read buffer. The host drains that buffer through a valid/ready read port.

The block raises a receive interrupt in three cases:
- after every eighth stored byte, with state code 5h;
- when the announced count has been reached, with code 5h, even if the buffer is only partly full;
- when the frame ends short, with code 7h. A frame ends short after a bit-engine error, after a buffer overrun, or when the per-frame byte ceiling cuts it off.

The bit engine cannot pause the wire, so the incoming byte interface has no ready signal. A byte that finds the buffer full is lost and is reported as an overrun. On the read port, back-pressure works like this: while `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold steady. A byte leaves the buffer on each clock edge where both are high.

Top module: `mrx_rdbuf_ctrl`

## Requirements
- R1: Only a command code of 0h, 3h, 4h, 5h, 6h or 7h, presented with `cmd_valid` while idle, opens a frame. Any other code leaves `busy` low, stores nothing and leaves `len_rd` unchanged.
- R2: The first good byte after a frame opens is latched into `len_rd`. It is not stored in the buffer, and no interrupt is raised for it.
- R3: Data bytes come out on `rd_data` in arrival order. `rd_valid` and `rd_data` hold while `rd_ready` is low, and a byte is removed on each edge where both are high.
- R4: When the running data-byte count of a frame reaches a multiple of 8 and the frame goes on, `state_code` becomes 5h and `rx_irq` pulses while `busy` stays high.
- R5: When the stored byte count equals the announced length, the frame ends: `busy` falls, `state_code` becomes 5h and `rx_irq` pulses, whatever the buffer fill level.
- R6: An announced length of 0 stands for 256 bytes.
- R7: A data byte arriving while the buffer holds 8 bytes and no read takes place in that cycle is dropped. It sets `overrun`, and the frame ends with code 7h and an interrupt. `overrun` is cleared when the next frame opens.
- R8: A byte flagged with `rx_err`, whether it is the length byte or a data byte, is discarded, and the frame ends with code 7h and an interrupt.
- R9: When the count reaches the MAX_BYTES ceiling (32 by default) and the announced length is larger, the frame ends with code 7h. If the length equals the ceiling, code 5h is given instead.
- R10: `rx_irq` is high for exactly one cycle, the cycle after the accepting edge. `state_code` holds until the next event, or until `code_clr` returns it to 0h.
- R11: After reset, `busy`, `rx_irq`, `overrun` and `rd_valid` are low, and `state_code` and `len_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command code sent on the bus this cycle |
| cmd_code | input | 4 | Command code value |
| rx_valid | input | 1 | Byte delivered by the bit engine |
| rx_data | input | 8 | Delivered byte |
| rx_err | input | 1 | Delivered byte is in error |
| rd_valid | output | 1 | Read buffer holds a byte |
| rd_ready | input | 1 | Host takes the byte |
| rd_data | output | 8 | Oldest buffered byte |
| len_rd | output | 8 | Latched announced length |
| state_code | output | 4 | Last state code (0h, 5h, 7h) |
| rx_irq | output | 1 | Receive interrupt pulse |
| overrun | output | 1 | Byte lost to a full buffer in this frame |
| busy | output | 1 | Frame in progress |
| code_clr | input | 1 | Host clears the state code |

## Verification
The hardest case to reach is the overrun. The byte must arrive on the one cycle when the buffer is exactly full and the host is not reading, and an interrupt for the eighth byte fires on the edge just before it. The stimulus holds `rd_ready` low for a frame longer than eight bytes, checks the group interrupt on the eighth byte, then sends the ninth and expects the code 7h ending. After that it drains the buffer and checks that only the first eight bytes come out. The byte-ceiling ending also takes a long frame. The bench keeps the host reading so that the buffer never overflows, and sends 32 bytes against a larger announced length.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic [3:0] {
    ST_NONE  = 4'h0,
    ST_GROUP = 4'h5,
    ST_SHORT = 4'h7
  } mrx_code_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LEN,
    PH_DATA
  } mrx_phase_e;

  function automatic logic is_read_code(input logic [3:0] c);
    return (c == 4'h0) || (c == 4'h3) || (c == 4'h4) ||
           (c == 4'h5) || (c == 4'h6) || (c == 4'h7);
  endfunction

endpackage

// File: rtl/mrx_fifo.sv
module mrx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = AW + 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;
  logic             do_pop;

  assign empty  = (fill == '0);
  assign full   = (fill == CNT_W'(DEPTH));
  assign do_pop = pop && !empty;
  assign dout   = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push)   wr_ptr <= bump(wr_ptr);
      if (do_pop) rd_ptr <= bump(rd_ptr);
      if (push && !do_pop)      fill <= fill + 1'b1;
      else if (do_pop && !push) fill <= fill - 1'b1;
    end
  end

endmodule

// File: rtl/mrx_frame_count.sv
module mrx_frame_count #(
  parameter int LW        = 8,
  parameter int MAX_BYTES = 32,
  parameter int GROUP     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          len_load,
  input  logic [LW-1:0] len_in,
  input  logic          inc,
  output logic [LW-1:0] len_q,
  output logic          hit_last,
  output logic          hit_max,
  output logic          hit_group
);
  localparam int LEN_SPAN = 1 << LW;
  localparam int TOP_CNT  = (MAX_BYTES > LEN_SPAN) ? MAX_BYTES : LEN_SPAN;
  localparam int CW       = $clog2(TOP_CNT + 1);

  logic [CW-1:0] cnt, cnt_nxt, len_eff;

  assign len_eff   = (len_q == '0) ? CW'(LEN_SPAN) : CW'(len_q);
  assign cnt_nxt   = cnt + 1'b1;
  assign hit_last  = (cnt_nxt == len_eff);
  assign hit_max   = (cnt_nxt == CW'(MAX_BYTES));
  assign hit_group = ((cnt_nxt % CW'(GROUP)) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      len_q <= '0;
    end else begin
      if (clr)           cnt <= '0;
      else if (inc)      cnt <= cnt_nxt;
      if (len_load)      len_q <= len_in;
    end
  end

endmodule

// File: rtl/mrx_frame_ctrl.sv
module mrx_frame_ctrl
  import mrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  input  logic       rx_valid,
  input  logic       rx_err,
  input  logic       buf_full,
  input  logic       buf_pop,
  input  logic       hit_last,
  input  logic       hit_max,
  input  logic       hit_group,
  input  logic       code_clr,
  output logic       cnt_clr,
  output logic       len_load,
  output logic       cnt_inc,
  output logic       buf_push,
  output logic       busy,
  output logic [3:0] state_code,
  output logic       rx_irq,
  output logic       overrun
);
  mrx_phase_e phase_q, phase_d;
  mrx_code_e  code_q, code_d;
  logic       irq_d, ovf_q, ovf_d;

  always_comb begin
    phase_d  = phase_q;
    code_d   = code_q;
    irq_d    = 1'b0;
    ovf_d    = ovf_q;
    cnt_clr  = 1'b0;
    len_load = 1'b0;
    cnt_inc  = 1'b0;
    buf_push = 1'b0;
    if (code_clr) code_d = ST_NONE;
    case (phase_q)
      PH_IDLE: begin
        if (cmd_valid && is_read_code(cmd_code)) begin
          phase_d = PH_LEN;
          cnt_clr = 1'b1;
          ovf_d   = 1'b0;
        end
      end
      PH_LEN: begin
        if (rx_valid) begin
          if (rx_err) begin
            phase_d = PH_IDLE;
            code_d  = ST_SHORT;
            irq_d   = 1'b1;
          end else begin
            len_load = 1'b1;
            phase_d  = PH_DATA;
          end
        end
      end
      PH_DATA: begin
        if (rx_valid) begin
          if (rx_err) begin
            phase_d = PH_IDLE;
            code_d  = ST_SHORT;
            irq_d   = 1'b1;
          end else if (buf_full && !buf_pop) begin
            ovf_d   = 1'b1;
            phase_d = PH_IDLE;
            code_d  = ST_SHORT;
            irq_d   = 1'b1;
          end else begin
            buf_push = 1'b1;
            cnt_inc  = 1'b1;
            if (hit_last) begin
              phase_d = PH_IDLE;
              code_d  = ST_GROUP;
              irq_d   = 1'b1;
            end else if (hit_max) begin
              phase_d = PH_IDLE;
              code_d  = ST_SHORT;
              irq_d   = 1'b1;
            end else if (hit_group) begin
              code_d = ST_GROUP;
              irq_d  = 1'b1;
            end
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      code_q  <= ST_NONE;
      rx_irq  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      code_q  <= code_d;
      rx_irq  <= irq_d;
      ovf_q   <= ovf_d;
    end
  end

  assign busy       = (phase_q != PH_IDLE);
  assign state_code = code_q;
  assign overrun    = ovf_q;

endmodule

// File: rtl/mrx_rdbuf_ctrl.sv
module mrx_rdbuf_ctrl #(
  parameter int DW        = 8,
  parameter int DEPTH     = 8,
  parameter int GROUP     = 8,
  parameter int MAX_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_code,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_err,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] len_rd,
  output logic [3:0]    state_code,
  output logic          rx_irq,
  output logic          overrun,
  output logic          busy,
  input  logic          code_clr
);
  logic buf_empty, buf_full, buf_push, buf_pop;
  logic cnt_clr, len_load, cnt_inc;
  logic hit_last, hit_max, hit_group;

  assign rd_valid = !buf_empty;
  assign buf_pop  = rd_valid && rd_ready;

  mrx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(buf_push), .push_data(rx_data),
    .pop(buf_pop), .dout(rd_data),
    .empty(buf_empty), .full(buf_full)
  );

  mrx_frame_count #(.LW(DW), .MAX_BYTES(MAX_BYTES), .GROUP(GROUP)) u_count (
    .clk(clk), .rst_n(rst_n),
    .clr(cnt_clr), .len_load(len_load), .len_in(rx_data), .inc(cnt_inc),
    .len_q(len_rd), .hit_last(hit_last), .hit_max(hit_max), .hit_group(hit_group)
  );

  mrx_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rx_valid(rx_valid), .rx_err(rx_err),
    .buf_full(buf_full), .buf_pop(buf_pop),
    .hit_last(hit_last), .hit_max(hit_max), .hit_group(hit_group),
    .code_clr(code_clr),
    .cnt_clr(cnt_clr), .len_load(len_load), .cnt_inc(cnt_inc), .buf_push(buf_push),
    .busy(busy), .state_code(state_code), .rx_irq(rx_irq), .overrun(overrun)
  );

endmodule

// File: rtl/mrx_rdbuf_chk.sv
module mrx_rdbuf_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [3:0]    cmd_code,
  input logic          busy,
  input logic          rx_irq,
  input logic [3:0]    state_code,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          overrun,
  input logic          buf_full
);
  logic read_type;
  assign read_type = mrx_pkg::is_read_code(cmd_code);

  // R1
  non_read_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !read_type) |=> !busy);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R7
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(buf_full));

  // R10
  irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (state_code == 4'h5 || state_code == 4'h7));

  // R5
  frame_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_irq);

endmodule

bind mrx_rdbuf_ctrl mrx_rdbuf_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .busy(busy), .rx_irq(rx_irq), .state_code(state_code),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .overrun(overrun), .buf_full(buf_full)
);

// File: tb/mrx_rdbuf_ctrl_bench.sv
module mrx_rdbuf_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'h0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_err = 1'b0;
  logic       rd_ready = 1'b0;
  logic       code_clr = 1'b0;
  logic       rd_valid, rx_irq, overrun, busy;
  logic [7:0] rd_data, len_rd;
  logic [3:0] state_code;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [7:0] sb[$];

  always #4 clk = ~clk;

  mrx_rdbuf_ctrl u_mrx_rdbuf_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .len_rd(len_rd), .state_code(state_code), .rx_irq(rx_irq),
    .overrun(overrun), .busy(busy), .code_clr(code_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read handshake (R3)
  always @(negedge clk) begin
    #2;
    if (rst_n && rd_valid && rd_ready) begin
      if (sb.size() == 0) chk(1'b0, "R3 unexpected byte", int'(rd_data), -1);
      else begin
        logic [7:0] e;
        e = sb.pop_front();
        chk(rd_data == e, "R3 read order", int'(rd_data), int'(e));
      end
    end
  end

  task automatic start(input logic [3:0] c, input bit exp_busy, input string req);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0;
    chk(busy == exp_busy, req, int'(busy), int'(exp_busy));
  endtask

  task automatic send(input logic [7:0] d, input bit err, input bit store,
                      input bit exp_irq, input logic [3:0] exp_code, input string req);
    @(negedge clk); rx_valid = 1'b1; rx_data = d; rx_err = err;
    if (store) sb.push_back(d);
    @(negedge clk); rx_valid = 1'b0; rx_err = 1'b0;
    chk(rx_irq == exp_irq, req, int'(rx_irq), int'(exp_irq));
    if (exp_irq) begin
      chk(state_code == exp_code, req, int'(state_code), int'(exp_code));
      @(negedge clk);
      chk(rx_irq == 1'b0, "R10 single-cycle pulse", int'(rx_irq), 0);
    end
  endtask

  task automatic drain();
    @(negedge clk); rd_ready = 1'b1;
    repeat (12) @(negedge clk);
    rd_ready = 1'b0;
    chk(sb.size() == 0, "R3 drained", sb.size(), 0);
  endtask

  task automatic long_frame(input logic [7:0] len, input int n, input logic [3:0] last_code,
                            input string req);
    start(4'h6, 1'b1, "R1 read code opens");
    send(len, 1'b0, 1'b0, 1'b0, 4'h0, "R2 length silent");
    rd_ready = 1'b1;
    for (int i = 1; i <= n; i++) begin
      if (i == n)          send(8'(i), 1'b0, 1'b1, 1'b1, last_code, req);
      else if (i % 8 == 0) send(8'(i), 1'b0, 1'b1, 1'b1, 4'h5, "R4 group in long frame");
      else                 send(8'(i), 1'b0, 1'b1, 1'b0, 4'h0, "R4 no irq mid group");
    end
    chk(busy == 1'b0, req, int'(busy), 0);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !rx_irq && !overrun && !rd_valid, "R11 reset flags",
        {busy, rx_irq, overrun, rd_valid}, 0);
    chk(state_code == 4'h0 && len_rd == 8'h00, "R11 reset regs",
        {state_code, len_rd}, 0);

    // R1 non-read code ignored
    start(4'h1, 1'b0, "R1 code 1 ignored");
    send(8'hAA, 1'b0, 1'b0, 1'b0, 4'h0, "R1 no irq");
    @(negedge clk);
    chk(!rd_valid && len_rd == 8'h00, "R1 nothing stored", {rd_valid, len_rd}, 0);

    // R2 / R5 short frame, host reading
    rd_ready = 1'b1;
    start(4'h3, 1'b1, "R1 code 3 opens");
    send(8'd5, 1'b0, 1'b0, 1'b0, 4'h0, "R2 length no irq");
    chk(len_rd == 8'd5, "R2 length latched", int'(len_rd), 5);
    for (int i = 0; i < 5; i++)
      send(8'h10 + 8'(i), 1'b0, 1'b1, i == 4, 4'h5, "R5 last byte partial");
    chk(busy == 1'b0, "R5 frame ended", int'(busy), 0);
    drain();

    // R4 group of eight with back-pressure, then R5 end at 12
    start(4'h0, 1'b1, "R1 code 0 opens");
    send(8'd12, 1'b0, 1'b0, 1'b0, 4'h0, "R2 length no irq");
    for (int i = 1; i <= 8; i++)
      send(8'h20 + 8'(i), 1'b0, 1'b1, i == 8, 4'h5, "R4 eighth byte");
    chk(busy == 1'b1 && rd_valid, "R4 frame continues", {busy, rd_valid}, 3);
    drain();
    for (int i = 9; i <= 12; i++)
      send(8'h20 + 8'(i), 1'b0, 1'b1, i == 12, 4'h5, "R5 end at twelve");
    drain();

    // R10 host clear
    @(negedge clk); code_clr = 1'b1;
    @(negedge clk); code_clr = 1'b0;
    chk(state_code == 4'h0, "R10 code cleared", int'(state_code), 0);

    // R7 overrun
    start(4'h4, 1'b1, "R1 code 4 opens");
    send(8'd10, 1'b0, 1'b0, 1'b0, 4'h0, "R2 length no irq");
    for (int i = 1; i <= 8; i++)
      send(8'h40 + 8'(i), 1'b0, 1'b1, i == 8, 4'h5, "R4 eighth before overrun");
    send(8'h49, 1'b0, 1'b0, 1'b1, 4'h7, "R7 overrun code");
    chk(overrun == 1'b1 && busy == 1'b0, "R7 overrun flag", {overrun, busy}, 2);
    drain();
    start(4'h5, 1'b1, "R1 code 5 opens");
    chk(overrun == 1'b0, "R7 overrun cleared on open", int'(overrun), 0);

    // R8 error on data byte
    send(8'd6, 1'b0, 1'b0, 1'b0, 4'h0, "R2 length no irq");
    send(8'h61, 1'b0, 1'b1, 1'b0, 4'h0, "R8 before error");
    send(8'h62, 1'b0, 1'b1, 1'b0, 4'h0, "R8 before error");
    send(8'h63, 1'b1, 1'b0, 1'b1, 4'h7, "R8 error ends short");
    chk(busy == 1'b0, "R8 frame ended", int'(busy), 0);
    drain();

    // R8 error on length byte
    start(4'h7, 1'b1, "R1 code 7 opens");
    send(8'd3, 1'b1, 1'b0, 1'b1, 4'h7, "R8 length error");
    chk(len_rd == 8'd6 && !busy, "R8 length not latched", {len_rd, 7'd0, busy}, 16'h0600);

    // R9 ceiling below announced length, ceiling equal to length, R6 zero length
    long_frame(8'd40, 32, 4'h7, "R9 ceiling cuts short");
    long_frame(8'd32, 32, 4'h5, "R9 ceiling equals length");
    long_frame(8'd0,  32, 4'h7, "R6 zero means 256");

    chk(sb.size() == 0, "R3 scoreboard empty", sb.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule